// File: doc/BRIEF.md
# Ordered Memory Access Scheduler

This block orders the memory traffic of an out-of-order core. Stores wait in a small write buffer and loads wait in a read queue. Each entry carries the instruction's age, its address and, for stores, the data. Either item may still be unresolved when the entry is enqueued; a shared resolve port, keyed by age, fills it in later. Stores never reach memory before their instruction commits. The commit stage names the retiring instruction's age on the retire port.

One access is chosen per cycle under a fixed policy. A retired store whose address and data are known wins first, the oldest such store. When no store qualifies, the oldest load that may proceed is taken. A load may proceed once its own address is known and every store older than it has a known address. If an older buffered store matches that load's address, the data is taken from the youngest such store and returned on the response port, with no memory request. Otherwise the load goes to memory. A flush input discards speculative work after a misprediction or exception.

Ages come from a wrapping counter that is one bit wider than the age range needed. Order is decided by modular subtraction, so at most 2^(AGE_W-1) instructions may be in flight.

Top module: `mem_order_sched`

## Requirements
- R1: A buffered store produces no memory request until `ret_age` equal to its age has been presented with `ret_valid`. From the next cycle on, it may be requested with `mem_req_write`=1 and its address and data.
- R2: While any retired store with a known address and data is buffered, the memory request is a store (`mem_req_write`=1), even when older loads are waiting.
- R3: Among eligible retired stores, the one with the oldest age is requested first.
- R4: When no store is eligible, the oldest load that may proceed is the one presented, either on the memory request port or on the response port.
- R5: A load is held, with no request and no response, while its address is unknown or while any older buffered store has an unknown address.
- R6: A load whose address equals that of one or more older buffered stores gets `rsp_valid`=1 with the data of the youngest of those stores and its own age. It makes no memory request and leaves the queue at the next edge.
- R7: Stores younger than a load are never used to forward data to it. A load with no older matching store is sent to memory with `mem_req_write`=0.
- R8: After reset both queues are empty, with `wr_ready`=1 and `rd_ready`=1. `wr_ready` is 0 when all write-buffer slots are used, and `rd_ready` is 0 when all read-queue slots are used.
- R9: A memory request not accepted (`mem_ready`=0) is still presented on the next cycle. It is removed at the edge where `mem_ready`=1.
- R10: A flush removes every load and every unretired store whose age is younger than `flush_age`. Retired stores are kept.
- R11: Age order is modular. Age a is older than age b when (a-b) mod 2^AGE_W has its top bit set, so for AGE_W=4 age 15 is older than age 0.
- R12: A resolve presented with `rsv_valid` sets the address of the unresolved load or store of age `rsv_age`, and for a store also its data. That entry then becomes eligible under R1 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| wr_valid | input | 1 | store enqueue request |
| wr_ready | output | 1 | write buffer has a free slot |
| wr_age | input | AGE_W | store age |
| wr_known | input | 1 | store address and data valid at enqueue |
| wr_addr | input | AW | store address |
| wr_data | input | DW | store data |
| rd_valid | input | 1 | load enqueue request |
| rd_ready | output | 1 | read queue has a free slot |
| rd_age | input | AGE_W | load age |
| rd_known | input | 1 | load address valid at enqueue |
| rd_addr | input | AW | load address |
| rsv_valid | input | 1 | late address/data resolve |
| rsv_age | input | AGE_W | age of the entry being resolved |
| rsv_addr | input | AW | resolved address |
| rsv_data | input | DW | resolved store data |
| ret_valid | input | 1 | instruction retires |
| ret_age | input | AGE_W | age of retiring instruction |
| flush_valid | input | 1 | discard younger work |
| flush_age | input | AGE_W | entries younger than this are discarded |
| mem_req_valid | output | 1 | memory access presented |
| mem_ready | input | 1 | memory accepts the access |
| mem_req_write | output | 1 | 1 store, 0 load |
| mem_req_age | output | AGE_W | age of presented access |
| mem_req_addr | output | AW | address of presented access |
| mem_req_data | output | DW | store data, zero for loads |
| rsp_valid | output | 1 | forwarded load result |
| rsp_age | output | AGE_W | age of forwarded load |
| rsp_data | output | DW | forwarded data |

## Verification
All outputs are decoded combinationally from registered entry state. A request, response or ready change caused by an enqueue, resolve, retire, flush or acceptance therefore appears right after the edge that captures that stimulus. The bench changes inputs 1 ns after a rising edge, advances exactly one edge per stimulus, and samples outputs 1 ns after that edge. Stall behaviour (R9) is checked by holding `mem_ready` low across an extra edge before the expected value is read.

// File: rtl/mos_pkg.sv
package mos_pkg;

   // a is older than b when a-b, taken modulo 2^w, has its top bit set
   function automatic logic age_older(input logic [31:0] a, input logic [31:0] b, input int w);
      logic [31:0] d;
      d = (a - b) & ((32'd1 << w) - 32'd1);
      return (d != 32'd0) && d[w-1];
   endfunction

endpackage

// File: rtl/mos_wbuf.sv
module mos_wbuf
   import mos_pkg::*;
#(
   parameter int AW     = 8,
   parameter int DW     = 8,
   parameter int AGE_W  = 4,
   parameter int DEPTH  = 4,
   parameter bit FWD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enq_valid,
   output logic             enq_ready,
   input  logic [AGE_W-1:0] enq_age,
   input  logic             enq_known,
   input  logic [AW-1:0]    enq_addr,
   input  logic [DW-1:0]    enq_data,
   input  logic             rsv_valid,
   input  logic [AGE_W-1:0] rsv_age,
   input  logic [AW-1:0]    rsv_addr,
   input  logic [DW-1:0]    rsv_data,
   input  logic             ret_valid,
   input  logic [AGE_W-1:0] ret_age,
   input  logic             flush_valid,
   input  logic [AGE_W-1:0] flush_age,
   input  logic             fire,
   output logic             sel_valid,
   output logic [AGE_W-1:0] sel_age,
   output logic [AW-1:0]    sel_addr,
   output logic [DW-1:0]    sel_data,
   output logic             unk_any,
   output logic [AGE_W-1:0] unk_age,
   input  logic [AGE_W-1:0] look_age,
   input  logic [AW-1:0]    look_addr,
   output logic             fwd_hit,
   output logic [DW-1:0]    fwd_data
);
   localparam int IW = $clog2(DEPTH);

   logic [DEPTH-1:0] v_q, known_q, ret_q;
   logic [AGE_W-1:0] age_q  [DEPTH];
   logic [AW-1:0]    addr_q [DEPTH];
   logic [DW-1:0]    data_q [DEPTH];
   logic [IW-1:0]    free_idx, sel_idx, unk_idx;

   assign enq_ready = ~(&v_q);

   always_comb begin
      free_idx = '0;
      for (int i = DEPTH-1; i >= 0; i--)
         if (!v_q[i]) free_idx = IW'(i);
   end

   // oldest retired entry with address and data known
   always_comb begin
      sel_valid = 1'b0;
      sel_idx   = '0;
      for (int i = 0; i < DEPTH; i++)
         if (v_q[i] && known_q[i] && ret_q[i] &&
             (!sel_valid || age_older(32'(age_q[i]), 32'(age_q[sel_idx]), AGE_W))) begin
            sel_valid = 1'b1;
            sel_idx   = IW'(i);
         end
   end
   assign sel_age  = age_q[sel_idx];
   assign sel_addr = addr_q[sel_idx];
   assign sel_data = data_q[sel_idx];

   // oldest entry whose address is still unknown
   always_comb begin
      unk_any = 1'b0;
      unk_idx = '0;
      for (int i = 0; i < DEPTH; i++)
         if (v_q[i] && !known_q[i] &&
             (!unk_any || age_older(32'(age_q[i]), 32'(age_q[unk_idx]), AGE_W))) begin
            unk_any = 1'b1;
            unk_idx = IW'(i);
         end
   end
   assign unk_age = age_q[unk_idx];

   generate
      if (FWD_EN) begin : g_fwd
         logic [IW-1:0] fwd_idx;
         // youngest known entry older than the load with the same address
         always_comb begin
            fwd_hit = 1'b0;
            fwd_idx = '0;
            for (int i = 0; i < DEPTH; i++)
               if (v_q[i] && known_q[i] && addr_q[i] == look_addr &&
                   age_older(32'(age_q[i]), 32'(look_age), AGE_W) &&
                   (!fwd_hit || age_older(32'(age_q[fwd_idx]), 32'(age_q[i]), AGE_W))) begin
                  fwd_hit = 1'b1;
                  fwd_idx = IW'(i);
               end
         end
         assign fwd_data = data_q[fwd_idx];
      end else begin : g_nofwd
         assign fwd_hit  = 1'b0;
         assign fwd_data = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q     <= '0;
         known_q <= '0;
         ret_q   <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            age_q[i]  <= '0;
            addr_q[i] <= '0;
            data_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (fire && sel_valid && sel_idx == IW'(i)) v_q[i] <= 1'b0;
            if (ret_valid && v_q[i] && age_q[i] == ret_age) ret_q[i] <= 1'b1;
            if (rsv_valid && v_q[i] && !known_q[i] && age_q[i] == rsv_age) begin
               known_q[i] <= 1'b1;
               addr_q[i]  <= rsv_addr;
               data_q[i]  <= rsv_data;
            end
            if (flush_valid && v_q[i] && !ret_q[i] &&
                age_older(32'(flush_age), 32'(age_q[i]), AGE_W)) v_q[i] <= 1'b0;
            if (enq_valid && enq_ready && free_idx == IW'(i)) begin
               v_q[i]     <= 1'b1;
               known_q[i] <= enq_known;
               ret_q[i]   <= 1'b0;
               age_q[i]   <= enq_age;
               addr_q[i]  <= enq_addr;
               data_q[i]  <= enq_data;
            end
         end
      end
   end

   // R8: an accepted store occupies exactly one more slot
   assert_wr_enq_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      enq_valid && enq_ready && !fire && !flush_valid
      |=> $countones(v_q) == $past($countones(v_q)) + 1);

endmodule

// File: rtl/mos_rdq.sv
module mos_rdq
   import mos_pkg::*;
#(
   parameter int AW    = 8,
   parameter int AGE_W = 4,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enq_valid,
   output logic             enq_ready,
   input  logic [AGE_W-1:0] enq_age,
   input  logic             enq_known,
   input  logic [AW-1:0]    enq_addr,
   input  logic             rsv_valid,
   input  logic [AGE_W-1:0] rsv_age,
   input  logic [AW-1:0]    rsv_addr,
   input  logic             flush_valid,
   input  logic [AGE_W-1:0] flush_age,
   input  logic             blk_any,
   input  logic [AGE_W-1:0] blk_age,
   input  logic             pop,
   output logic             sel_valid,
   output logic [AGE_W-1:0] sel_age,
   output logic [AW-1:0]    sel_addr
);
   localparam int IW = $clog2(DEPTH);

   logic [DEPTH-1:0] v_q, known_q, go;
   logic [AGE_W-1:0] age_q  [DEPTH];
   logic [AW-1:0]    addr_q [DEPTH];
   logic [IW-1:0]    free_idx, sel_idx;

   assign enq_ready = ~(&v_q);

   always_comb begin
      free_idx = '0;
      for (int i = DEPTH-1; i >= 0; i--)
         if (!v_q[i]) free_idx = IW'(i);
   end

   // a load may go once known and no older store address is unknown
   always_comb begin
      for (int i = 0; i < DEPTH; i++)
         go[i] = v_q[i] && known_q[i] &&
                 !(blk_any && age_older(32'(blk_age), 32'(age_q[i]), AGE_W));
      sel_valid = 1'b0;
      sel_idx   = '0;
      for (int i = 0; i < DEPTH; i++)
         if (go[i] && (!sel_valid || age_older(32'(age_q[i]), 32'(age_q[sel_idx]), AGE_W))) begin
            sel_valid = 1'b1;
            sel_idx   = IW'(i);
         end
   end
   assign sel_age  = age_q[sel_idx];
   assign sel_addr = addr_q[sel_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q     <= '0;
         known_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            age_q[i]  <= '0;
            addr_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (pop && sel_valid && sel_idx == IW'(i)) v_q[i] <= 1'b0;
            if (rsv_valid && v_q[i] && !known_q[i] && age_q[i] == rsv_age) begin
               known_q[i] <= 1'b1;
               addr_q[i]  <= rsv_addr;
            end
            if (flush_valid && v_q[i] && age_older(32'(flush_age), 32'(age_q[i]), AGE_W))
               v_q[i] <= 1'b0;
            if (enq_valid && enq_ready && free_idx == IW'(i)) begin
               v_q[i]     <= 1'b1;
               known_q[i] <= enq_known;
               age_q[i]   <= enq_age;
               addr_q[i]  <= enq_addr;
            end
         end
      end
   end

   // checker state for the flush property
   logic             fl_q, fl_enq_q, stale;
   logic [AGE_W-1:0] fl_age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_q     <= 1'b0;
         fl_enq_q <= 1'b0;
         fl_age_q <= '0;
      end else begin
         fl_q     <= flush_valid;
         fl_enq_q <= enq_valid;
         fl_age_q <= flush_age;
      end
   end
   always_comb begin
      stale = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         if (v_q[i] && age_older(32'(fl_age_q), 32'(age_q[i]), AGE_W)) stale = 1'b1;
   end

   // R10: no load younger than the flush age survives the flush
   assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fl_q && !fl_enq_q |-> !stale);

   // R8: an accepted load occupies exactly one more slot
   assert_rd_enq_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      enq_valid && enq_ready && !pop && !flush_valid
      |=> $countones(v_q) == $past($countones(v_q)) + 1);

endmodule

// File: rtl/mem_order_sched.sv
module mem_order_sched #(
   parameter int AW       = 8,
   parameter int DW       = 8,
   parameter int AGE_W    = 4,
   parameter int WB_DEPTH = 4,
   parameter int RQ_DEPTH = 4,
   parameter bit FWD_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   output logic             wr_ready,
   input  logic [AGE_W-1:0] wr_age,
   input  logic             wr_known,
   input  logic [AW-1:0]    wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic             rd_valid,
   output logic             rd_ready,
   input  logic [AGE_W-1:0] rd_age,
   input  logic             rd_known,
   input  logic [AW-1:0]    rd_addr,
   input  logic             rsv_valid,
   input  logic [AGE_W-1:0] rsv_age,
   input  logic [AW-1:0]    rsv_addr,
   input  logic [DW-1:0]    rsv_data,
   input  logic             ret_valid,
   input  logic [AGE_W-1:0] ret_age,
   input  logic             flush_valid,
   input  logic [AGE_W-1:0] flush_age,
   output logic             mem_req_valid,
   input  logic             mem_ready,
   output logic             mem_req_write,
   output logic [AGE_W-1:0] mem_req_age,
   output logic [AW-1:0]    mem_req_addr,
   output logic [DW-1:0]    mem_req_data,
   output logic             rsp_valid,
   output logic [AGE_W-1:0] rsp_age,
   output logic [DW-1:0]    rsp_data
);
   localparam int IN_FLIGHT = WB_DEPTH + RQ_DEPTH;

   generate
      if (WB_DEPTH < 2 || RQ_DEPTH < 2) begin : g_bad_depth
         $error("queue depths must be at least 2");
      end
      if ((1 << (AGE_W-1)) < IN_FLIGHT) begin : g_bad_age
         $error("AGE_W too narrow for the number of entries in flight");
      end
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("address and data widths must be positive");
      end
   endgenerate

   logic             wb_sel_valid, wb_fire, unk_any, fwd_hit;
   logic [AGE_W-1:0] wb_sel_age, unk_age;
   logic [AW-1:0]    wb_sel_addr;
   logic [DW-1:0]    wb_sel_data, fwd_data;
   logic             rq_sel_valid, rq_pop, rd_mem;
   logic [AGE_W-1:0] rq_sel_age;
   logic [AW-1:0]    rq_sel_addr;

   mos_wbuf #(.AW(AW), .DW(DW), .AGE_W(AGE_W), .DEPTH(WB_DEPTH), .FWD_EN(FWD_EN)) u_wbuf (
      .clk, .rst_n,
      .enq_valid(wr_valid), .enq_ready(wr_ready), .enq_age(wr_age),
      .enq_known(wr_known), .enq_addr(wr_addr), .enq_data(wr_data),
      .rsv_valid, .rsv_age, .rsv_addr, .rsv_data,
      .ret_valid, .ret_age, .flush_valid, .flush_age,
      .fire(wb_fire),
      .sel_valid(wb_sel_valid), .sel_age(wb_sel_age),
      .sel_addr(wb_sel_addr), .sel_data(wb_sel_data),
      .unk_any, .unk_age,
      .look_age(rq_sel_age), .look_addr(rq_sel_addr),
      .fwd_hit, .fwd_data
   );

   mos_rdq #(.AW(AW), .AGE_W(AGE_W), .DEPTH(RQ_DEPTH)) u_rdq (
      .clk, .rst_n,
      .enq_valid(rd_valid), .enq_ready(rd_ready), .enq_age(rd_age),
      .enq_known(rd_known), .enq_addr(rd_addr),
      .rsv_valid, .rsv_age, .rsv_addr,
      .flush_valid, .flush_age,
      .blk_any(unk_any), .blk_age(unk_age),
      .pop(rq_pop),
      .sel_valid(rq_sel_valid), .sel_age(rq_sel_age), .sel_addr(rq_sel_addr)
   );

   // store first; a load only when no store is eligible
   always_comb begin
      rd_mem        = !wb_sel_valid && rq_sel_valid && !fwd_hit;
      mem_req_valid = wb_sel_valid || rd_mem;
      mem_req_write = wb_sel_valid;
      mem_req_age   = wb_sel_valid ? wb_sel_age  : rq_sel_age;
      mem_req_addr  = wb_sel_valid ? wb_sel_addr : rq_sel_addr;
      mem_req_data  = wb_sel_valid ? wb_sel_data : '0;
      rsp_valid     = !wb_sel_valid && rq_sel_valid && fwd_hit;
      rsp_age       = rq_sel_age;
      rsp_data      = fwd_data;
      wb_fire       = wb_sel_valid && mem_ready;
      rq_pop        = rsp_valid || (rd_mem && mem_ready);
   end

   // R9: a refused request is still there on the next cycle
   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_ready && !flush_valid |=> mem_req_valid);

   // R3: a refused store request keeps its address until accepted
   assert_wr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write && !mem_ready
      |=> mem_req_write && $stable(mem_req_addr) && $stable(mem_req_age));

   // R6: a forwarded response is never paired with a load request
   assert_fwd_no_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !(mem_req_valid && !mem_req_write));

endmodule

// File: tb/sim_mem_order_sched.sv
module sim_mem_order_sched;
   localparam int AW = 8, DW = 8, AGE_W = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_valid = 0, wr_known = 0, rd_valid = 0, rd_known = 0;
   logic rsv_valid = 0, ret_valid = 0, flush_valid = 0, mem_ready = 0;
   logic [AGE_W-1:0] wr_age = 0, rd_age = 0, rsv_age = 0, ret_age = 0, flush_age = 0;
   logic [AW-1:0] wr_addr = 0, rd_addr = 0, rsv_addr = 0;
   logic [DW-1:0] wr_data = 0, rsv_data = 0;
   logic wr_ready, rd_ready, mem_req_valid, mem_req_write, rsp_valid;
   logic [AGE_W-1:0] mem_req_age, rsp_age;
   logic [AW-1:0] mem_req_addr;
   logic [DW-1:0] mem_req_data, rsp_data;

   int checks = 0, errors = 0, cycles = 0;

   mem_order_sched u0 (
      .clk, .rst_n, .wr_valid, .wr_ready, .wr_age, .wr_known, .wr_addr, .wr_data,
      .rd_valid, .rd_ready, .rd_age, .rd_known, .rd_addr,
      .rsv_valid, .rsv_age, .rsv_addr, .rsv_data,
      .ret_valid, .ret_age, .flush_valid, .flush_age,
      .mem_req_valid, .mem_ready, .mem_req_write, .mem_req_age, .mem_req_addr, .mem_req_data,
      .rsp_valid, .rsp_age, .rsp_data
   );

   always #2 clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog expired, run hung");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic enq_wr(input int age, input bit known, input int addr, input int data);
      wr_valid = 1; wr_age = AGE_W'(age); wr_known = known;
      wr_addr = AW'(addr); wr_data = DW'(data);
      step();
      wr_valid = 0;
   endtask

   task automatic enq_rd(input int age, input bit known, input int addr);
      rd_valid = 1; rd_age = AGE_W'(age); rd_known = known; rd_addr = AW'(addr);
      step();
      rd_valid = 0;
   endtask

   task automatic retire(input int age);
      ret_valid = 1; ret_age = AGE_W'(age);
      step();
      ret_valid = 0;
   endtask

   task automatic resolve(input int age, input int addr, input int data);
      rsv_valid = 1; rsv_age = AGE_W'(age); rsv_addr = AW'(addr); rsv_data = DW'(data);
      step();
      rsv_valid = 0;
   endtask

   task automatic flush(input int age);
      flush_valid = 1; flush_age = AGE_W'(age);
      step();
      flush_valid = 0;
   endtask

   task automatic t_reset();
      chk("R8", "wr_ready after reset", int'(wr_ready), 1);
      chk("R8", "rd_ready after reset", int'(rd_ready), 1);
      chk("R8", "no request after reset", int'(mem_req_valid), 0);
      chk("R8", "no response after reset", int'(rsp_valid), 0);
   endtask

   task automatic t_retire_gate();
      enq_wr(1, 1, 'h10, 'hAA);
      chk("R1", "store held before retire", int'(mem_req_valid), 0);
      retire(1);
      chk("R1", "store requested after retire", int'(mem_req_valid), 1);
      chk("R1", "request is a store", int'(mem_req_write), 1);
      chk("R1", "store address", int'(mem_req_addr), 'h10);
      chk("R1", "store data", int'(mem_req_data), 'hAA);
      step();
      chk("R9", "refused store still presented", int'(mem_req_valid), 1);
      mem_ready = 1;
      step();
      mem_ready = 0;
      chk("R9", "accepted store removed", int'(mem_req_valid), 0);
   endtask

   task automatic t_priority();
      enq_rd(2, 1, 'h20);
      chk("R4", "lone load requested", int'(mem_req_valid), 1);
      chk("R7", "load goes to memory as read", int'(mem_req_write), 0);
      chk("R4", "load address", int'(mem_req_addr), 'h20);
      enq_wr(3, 1, 'h30, 'h55);
      retire(3);
      chk("R2", "retired store beats older load", int'(mem_req_write), 1);
      chk("R2", "store address wins", int'(mem_req_addr), 'h30);
      mem_ready = 1;
      step();
      chk("R4", "load follows store", int'(mem_req_addr), 'h20);
      chk("R4", "load kind", int'(mem_req_write), 0);
      step();
      mem_ready = 0;
      chk("R4", "queues drained", int'(mem_req_valid), 0);
   endtask

   task automatic t_forward_flush();
      enq_wr(4, 1, 'h40, 'h11);
      enq_wr(5, 1, 'h40, 'h22);
      enq_wr(7, 1, 'h40, 'h33);
      enq_rd(6, 1, 'h40);
      chk("R6", "forward response", int'(rsp_valid), 1);
      chk("R6", "youngest older store data", int'(rsp_data), 'h22);
      chk("R6", "response age", int'(rsp_age), 6);
      chk("R6", "no memory request on forward", int'(mem_req_valid), 0);
      step();
      chk("R6", "forwarded load leaves queue", int'(rsp_valid), 0);
      enq_rd(8, 1, 'h50);
      chk("R7", "no forward without match", int'(rsp_valid), 0);
      chk("R7", "unmatched load to memory", int'(mem_req_valid), 1);
      chk("R7", "unmatched load address", int'(mem_req_addr), 'h50);
      retire(4);
      chk("R2", "retired store preempts load", int'(mem_req_write), 1);
      flush(4);
      chk("R10", "retired store survives flush", int'(mem_req_valid), 1);
      chk("R10", "retired store data", int'(mem_req_data), 'h11);
      mem_ready = 1;
      step();
      mem_ready = 0;
      chk("R10", "flushed load and stores gone", int'(mem_req_valid), 0);
      chk("R10", "flushed load no response", int'(rsp_valid), 0);
   endtask

   task automatic t_unknown();
      enq_wr(9, 0, 0, 0);
      enq_rd(10, 1, 'h60);
      chk("R5", "load blocked by unknown older store", int'(mem_req_valid), 0);
      chk("R5", "blocked load no response", int'(rsp_valid), 0);
      resolve(9, 'h70, 'h44);
      chk("R12", "load released after resolve", int'(mem_req_valid), 1);
      chk("R12", "released load address", int'(mem_req_addr), 'h60);
      retire(9);
      chk("R12", "resolved store address", int'(mem_req_addr), 'h70);
      chk("R12", "resolved store data", int'(mem_req_data), 'h44);
      mem_ready = 1;
      step();
      step();
      mem_ready = 0;
      chk("R12", "drained after resolve test", int'(mem_req_valid), 0);
   endtask

   task automatic t_full_wrap();
      for (int k = 0; k < 4; k++) enq_wr(11 + k, 1, 'hB1 + k, 'hC0 + k);
      chk("R8", "wr_ready low when buffer full", int'(wr_ready), 0);
      for (int k = 0; k < 4; k++) enq_rd((15 + k) % 16, 1, 'hA0 + k);
      chk("R8", "rd_ready low when queue full", int'(rd_ready), 0);
      chk("R11", "age 15 older than 0", int'(mem_req_addr), 'hA0);
      mem_ready = 1;
      step();
      mem_ready = 0;
      chk("R11", "next after wrap is age 0", int'(mem_req_addr), 'hA1);
      chk("R8", "rd_ready back after pop", int'(rd_ready), 1);
      retire(11);
      retire(12);
      chk("R3", "oldest retired store first", int'(mem_req_addr), 'hB1);
      mem_ready = 1;
      step();
      chk("R3", "second store next", int'(mem_req_addr), 'hB2);
      step();
      mem_ready = 0;
      chk("R1", "unretired stores stay back", int'(mem_req_write), 0);
      flush(10);
      chk("R10", "flush empties queues", int'(mem_req_valid), 0);
      chk("R10", "wr_ready after flush", int'(wr_ready), 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1;
      step();
      t_reset();
      t_retire_gate();
      t_priority();
      t_forward_flush();
      t_unknown();
      t_full_wrap();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule